// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation cache after a lookup misses. It accepts the missing virtual address and splits the virtual page number into two indices: an upper index into a top-level table, and a lower index into a leaf table. It first reads the top-level entry. That entry tells it where the leaf table starts. It then reads the leaf entry, which is the final page-table entry. Both reads go out in that order through a simple request/response memory read port, and only one read is in flight at any time.

The top-level table starts at a root address that software programs before any walk. Every entry is 32 bits wide and bit 0 is its valid flag. The upper 20 bits of a valid entry give either the base of the next table or the physical frame number. If the final entry is valid, the walker pulses a refill toward the translation cache. If an entry at either level is invalid, the walker pulses a page-fault indication instead. The fault carries the level that failed and the faulting virtual address. The walker takes no new miss until the current walk has fully finished.

Top module: `pt_walk_engine`

## Requirements
- R1: While reset is asserted, the outputs hold these values: `missReady` = 1, `memReqValid` = 0, `refillValid` = 0 and `faultValid` = 0.
- R2: When `missValid` is sampled high while `missReady` is high, the walker issues one read in the next cycle. `memReqValid` is high for exactly that one cycle. `memReqAddr` = `rootBase` + 4 × VA[31:22].
- R3: In the cycle after a top-level response with bit 0 = 1, the walker issues a one-cycle leaf read. Its address is {entry[31:12], 12'h000} + 4 × VA[21:12]. The low 12 bits of the top-level entry have no effect on this address.
- R4: In the cycle after a leaf response with bit 0 = 1, `refillValid` is high for exactly one cycle. In that cycle `refillPte` equals the leaf entry and `refillVpn` equals VA[31:12].
- R5: A top-level response with bit 0 = 0 ends the walk. In the next cycle `faultValid` is high for one cycle, with `faultLevel` = 0 and `faultVaddr` equal to the missing address. No leaf read and no refill follow.
- R6: A leaf response with bit 0 = 0 gives, in the next cycle, a one-cycle `faultValid` with `faultLevel` = 1 and `faultVaddr` equal to the missing address. No refill follows.
- R7: A new read is never issued while an earlier read is still unanswered. `missReady` is low from the cycle after a miss is accepted until the cycle after the refill or fault pulse. A `missValid` seen during that time has no effect.
- R8: A response that arrives while the walker is idle has no effect. No request, refill or fault follows it, and `missReady` stays high.
- R9: The walker waits any number of cycles for each response, and its result timing is always counted from the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | A translation miss is presented |
| missVaddr | input | 32 | Virtual address that missed |
| missReady | output | 1 | Walker is idle and will accept a miss |
| rootBase | input | 32 | Start address of the top-level table, programmed by software |
| memReqValid | output | 1 | One-cycle read request |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data is valid this cycle |
| memRspData | input | 32 | Entry returned by memory |
| refillValid | output | 1 | One-cycle refill strobe to the translation cache |
| refillVpn | output | 20 | Virtual page number of the refill |
| refillPte | output | 32 | Final page-table entry |
| faultValid | output | 1 | One-cycle page-fault strobe |
| faultLevel | output | 1 | Level that failed: 0 = top-level, 1 = leaf |
| faultVaddr | output | 32 | Faulting virtual address |

## Verification
Every result is due a fixed number of cycles after the edge that causes it:
- The top-level read appears one cycle after the miss is accepted.
- The leaf read appears one cycle after the top-level response.
- The refill or fault pulse appears one cycle after the deciding response.
- `missReady` rises one cycle after that pulse.

A behavioural model in the bench advances on each rising edge, using only the stimulus and its own copy of the table image. It does not read the design. On each falling edge the bench compares every output against the model, so any result that comes one cycle early or late is caught. The memory model varies its latency from zero to seven cycles. This shows that all timing is counted from the response cycle and not from the request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Walk phases; order only matters for readability, not for decoding.
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_ISSUE_TOP,
    WK_WAIT_TOP,
    WK_ISSUE_LEAF,
    WK_WAIT_LEAF,
    WK_REFILL,
    WK_FAULT
  } walkState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic captureMiss;  // latch the missing address and the root base
    logic captureTop;   // latch leaf-table base from a valid top entry
    logic captureLeaf;  // latch the final entry
    logic leafSel;      // address mux: 1 = leaf read, 0 = top read
  } walkStrobe_t;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        memRspValid,
  input  logic        entryValid,
  output logic        missReady,
  output logic        memReqValid,
  output logic        refillValid,
  output logic        faultValid,
  output logic        faultLevel,
  output walkStrobe_t strobe
);

  walkState_e stateQ, stateD;
  logic       faultLvlQ, faultLvlD;

  always_comb begin
    stateD    = stateQ;
    faultLvlD = faultLvlQ;
    unique case (stateQ)
      WK_IDLE:       if (missValid) stateD = WK_ISSUE_TOP;
      WK_ISSUE_TOP:  stateD = WK_WAIT_TOP;
      WK_WAIT_TOP:
        if (memRspValid) begin
          if (entryValid) begin
            stateD = WK_ISSUE_LEAF;
          end else begin
            stateD    = WK_FAULT;
            faultLvlD = 1'b0;
          end
        end
      WK_ISSUE_LEAF: stateD = WK_WAIT_LEAF;
      WK_WAIT_LEAF:
        if (memRspValid) begin
          if (entryValid) begin
            stateD = WK_REFILL;
          end else begin
            stateD    = WK_FAULT;
            faultLvlD = 1'b1;
          end
        end
      WK_REFILL:     stateD = WK_IDLE;
      WK_FAULT:      stateD = WK_IDLE;
      default:       stateD = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= WK_IDLE;
      faultLvlQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      faultLvlQ <= faultLvlD;
    end
  end

  always_comb begin
    strobe.captureMiss = (stateQ == WK_IDLE) && missValid;
    strobe.captureTop  = (stateQ == WK_WAIT_TOP) && memRspValid && entryValid;
    strobe.captureLeaf = (stateQ == WK_WAIT_LEAF) && memRspValid && entryValid;
    strobe.leafSel     = (stateQ == WK_ISSUE_LEAF);
  end

  assign missReady   = (stateQ == WK_IDLE);
  assign memReqValid = (stateQ == WK_ISSUE_TOP) || (stateQ == WK_ISSUE_LEAF);
  assign refillValid = (stateQ == WK_REFILL);
  assign faultValid  = (stateQ == WK_FAULT);
  assign faultLevel  = faultLvlQ;

  // R7
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  // R7
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !missReady);
  // R4
  refill_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    refillValid |=> (!refillValid && missReady));
  // R5
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> (!faultValid && missReady));
  // R6
  result_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(refillValid && faultValid));
  // R8
  idle_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missReady && !missValid && memRspValid) |=> (missReady && !memReqValid));

endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import ptw_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int TOP_IDX_W  = 10,
  parameter int LEAF_IDX_W = 10,
  parameter int PTE_W      = 32,
  parameter int VALID_BIT  = 0
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  walkStrobe_t                            strobe,
  input  logic [VA_W-1:0]                        missVaddr,
  input  logic [PTE_W-1:0]                       rootBase,
  input  logic [PTE_W-1:0]                       memRspData,
  output logic [PTE_W-1:0]                       memReqAddr,
  output logic                                   entryValid,
  output logic [TOP_IDX_W+LEAF_IDX_W-1:0]        refillVpn,
  output logic [PTE_W-1:0]                       refillPte,
  output logic [VA_W-1:0]                        faultVaddr
);

  localparam int VPN_W  = TOP_IDX_W + LEAF_IDX_W;
  localparam int OFF_W  = VA_W - VPN_W;
  localparam int ADDR_W = PTE_W;
  localparam int ENT_SH = $clog2(PTE_W / 8);

  logic [VA_W-1:0]       vaQ;
  logic [ADDR_W-1:0]     rootQ;
  logic [ADDR_W-1:0]     leafBaseQ;
  logic [PTE_W-1:0]      pteQ;
  logic [TOP_IDX_W-1:0]  topIdx;
  logic [LEAF_IDX_W-1:0] leafIdx;

  assign topIdx  = vaQ[VA_W-1 -: TOP_IDX_W];
  assign leafIdx = vaQ[OFF_W +: LEAF_IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ       <= '0;
      rootQ     <= '0;
      leafBaseQ <= '0;
      pteQ      <= '0;
    end else begin
      if (strobe.captureMiss) begin
        vaQ   <= missVaddr;
        rootQ <= rootBase;
      end
      if (strobe.captureTop)
        leafBaseQ <= {memRspData[PTE_W-1:OFF_W], {OFF_W{1'b0}}};
      if (strobe.captureLeaf)
        pteQ <= memRspData;
    end
  end

  always_comb begin
    if (strobe.leafSel)
      memReqAddr = leafBaseQ + (ADDR_W'(leafIdx) << ENT_SH);
    else
      memReqAddr = rootQ + (ADDR_W'(topIdx) << ENT_SH);
  end

  assign entryValid = memRspData[VALID_BIT];
  assign refillVpn  = vaQ[VA_W-1:OFF_W];
  assign refillPte  = pteQ;
  assign faultVaddr = vaQ;

  // R7
  va_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureMiss |=> $stable(faultVaddr));
  // R4
  pte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureLeaf |=> $stable(refillPte));

endmodule

// File: rtl/pt_walk_engine.sv
module pt_walk_engine
  import ptw_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int TOP_IDX_W  = 10,
  parameter int LEAF_IDX_W = 10,
  parameter int PTE_W      = 32,
  parameter int VALID_BIT  = 0,
  localparam int VPN_W     = TOP_IDX_W + LEAF_IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [VA_W-1:0]   missVaddr,
  output logic              missReady,
  input  logic [PTE_W-1:0]  rootBase,
  output logic              memReqValid,
  output logic [PTE_W-1:0]  memReqAddr,
  input  logic              memRspValid,
  input  logic [PTE_W-1:0]  memRspData,
  output logic              refillValid,
  output logic [VPN_W-1:0]  refillVpn,
  output logic [PTE_W-1:0]  refillPte,
  output logic              faultValid,
  output logic              faultLevel,
  output logic [VA_W-1:0]   faultVaddr
);

  walkStrobe_t strobe;
  logic        entryValid;

  walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .memRspValid (memRspValid),
    .entryValid  (entryValid),
    .missReady   (missReady),
    .memReqValid (memReqValid),
    .refillValid (refillValid),
    .faultValid  (faultValid),
    .faultLevel  (faultLevel),
    .strobe      (strobe)
  );

  walk_dpath #(
    .VA_W       (VA_W),
    .TOP_IDX_W  (TOP_IDX_W),
    .LEAF_IDX_W (LEAF_IDX_W),
    .PTE_W      (PTE_W),
    .VALID_BIT  (VALID_BIT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .missVaddr  (missVaddr),
    .rootBase   (rootBase),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .entryValid (entryValid),
    .refillVpn  (refillVpn),
    .refillPte  (refillPte),
    .faultVaddr (faultVaddr)
  );

endmodule

// File: tb/tb_pt_walk_engine.sv
`timescale 1ns/1ps
module tb_pt_walk_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missVaddr = '0;
  logic        missReady;
  logic [31:0] rootBase = 32'h0001_0000;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        refillValid;
  logic [19:0] refillVpn;
  logic [31:0] refillPte;
  logic        faultValid;
  logic        faultLevel;
  logic [31:0] faultVaddr;

  always #2.5 clk = ~clk;

  pt_walk_engine dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missVaddr(missVaddr),
    .missReady(missReady), .rootBase(rootBase), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .refillValid(refillValid), .refillVpn(refillVpn), .refillPte(refillPte),
    .faultValid(faultValid), .faultLevel(faultLevel), .faultVaddr(faultVaddr)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Table image; absent addresses read as zero (invalid).
  logic [31:0] memImg [logic [31:0]];
  function automatic logic [31:0] img(input logic [31:0] a);
    return memImg.exists(a) ? memImg[a] : 32'h0;
  endfunction

  // Memory model: one response, memLat idle cycles after the request cycle.
  int          memLat = 0;
  bit          pend = 0;
  int          cnt = 0;
  logic [31:0] pendAddr = '0;
  logic        rspVq = 1'b0;
  logic [31:0] rspDq = '0;
  logic        stray = 1'b0;
  assign memRspValid = rspVq | stray;
  assign memRspData  = rspVq ? rspDq : 32'hFFFF_FFFF;

  // Reference model, advanced on rising edges from stimulus only.
  int          stage = 0;   // 0 idle, 1 top pending, 2 leaf pending, 3 finishing
  logic [31:0] mVa = '0, mBase = '0, eAddr = '0, ePte = '0, ent;
  bit          eReq = 0, eLeaf = 0, eRefill = 0, eFault = 0, eLvl = 0;

  always @(posedge clk) begin
    eReq = 0; eRefill = 0; eFault = 0;
    if (!rstN) stage = 0;
    else case (stage)
      0: if (missValid) begin
           mVa = missVaddr; mBase = rootBase;
           eReq = 1; eLeaf = 0;
           eAddr = rootBase + {20'h0, missVaddr[31:22], 2'b00};
           stage = 1;
         end
      1: if (memRspValid) begin
           ent = img(eAddr);
           if (ent[0]) begin
             eReq = 1; eLeaf = 1;
             eAddr = {ent[31:12], 12'h000} + {20'h0, mVa[21:12], 2'b00};
             stage = 2;
           end else begin
             eFault = 1; eLvl = 0; stage = 3;
           end
         end
      2: if (memRspValid) begin
           ent = img(eAddr);
           if (ent[0]) begin eRefill = 1; ePte = ent; end
           else begin eFault = 1; eLvl = 1; end
           stage = 3;
         end
      default: stage = 0;
    endcase
  end

  // Compare every cycle, then advance the memory model.
  always @(negedge clk) begin
    if (!finished) begin
      chk(missReady == (stage == 0), rstN ? "R7" : "R1", "missReady", missReady, stage == 0);
      chk(memReqValid == eReq, rstN ? "R2" : "R1", "memReqValid", memReqValid, eReq);
      if (eReq) chk(memReqAddr == eAddr, eLeaf ? "R3" : "R2", "memReqAddr", memReqAddr, eAddr);
      chk(refillValid == eRefill, rstN ? "R4/R9" : "R1", "refillValid", refillValid, eRefill);
      if (eRefill) begin
        chk(refillPte == ePte, "R4", "refillPte", refillPte, ePte);
        chk(refillVpn == mVa[31:12], "R4", "refillVpn", refillVpn, mVa[31:12]);
      end
      chk(faultValid == eFault, !rstN ? "R1" : (eLvl ? "R6" : "R5"), "faultValid", faultValid, eFault);
      if (eFault) begin
        chk(faultLevel == eLvl, eLvl ? "R6" : "R5", "faultLevel", faultLevel, eLvl);
        chk(faultVaddr == mVa, eLvl ? "R6" : "R5", "faultVaddr", faultVaddr, mVa);
      end
      rspVq = 1'b0;
      if (pend) begin
        if (cnt == 0) begin rspVq = 1'b1; rspDq = img(pendAddr); pend = 0; end
        else cnt--;
      end
      if (rstN && memReqValid) begin
        chk(!pend, "R7", "request while unanswered", 1, 0);
        pend = 1; cnt = memLat; pendAddr = memReqAddr;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic waitIdle();
    @(negedge clk); #0.5;
    while (!missReady) begin @(negedge clk); #0.5; end
  endtask

  task automatic walk(input logic [31:0] va, input int lat);
    memLat = lat;
    waitIdle();
    missValid = 1'b1; missVaddr = va;
    @(negedge clk); #0.5;
    missValid = 1'b0;
    waitIdle();
  endtask

  initial begin
    memImg[32'h0001_0004] = 32'h0002_0FFF;  // valid, junk low bits (R3)
    memImg[32'h0002_000C] = 32'hABCD_E007;
    memImg[32'h0001_0FFC] = 32'h0003_0001;
    memImg[32'h0003_0FFC] = 32'h1234_5003;
    memImg[32'h0008_0000] = 32'h0004_0001;
    memImg[32'h0004_0000] = 32'h0077_7001;

    repeat (3) @(negedge clk);
    #0.5 rstN = 1'b1;

    walk(32'h0040_3123, 0);   // R4 refill, top idx 1 / leaf idx 3
    walk(32'hFFFF_F000, 3);   // R9 maximal indices, latency 3
    walk(32'h0000_0ABC, 1);   // R5 top entry absent
    walk(32'h0040_5ABC, 2);   // R6 leaf entry absent

    // R7: misses offered during a long walk are ignored
    rootBase = 32'h0008_0000;
    memLat = 7;
    waitIdle();
    missValid = 1'b1; missVaddr = 32'h0000_0000;
    @(negedge clk); #0.5;
    missVaddr = 32'h0040_3000;
    repeat (2) begin @(negedge clk); #0.5; end
    missValid = 1'b0;
    waitIdle();

    // R8: stray response while idle
    stray = 1'b1;
    @(negedge clk); #0.5;
    stray = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(missReady && !memReqValid && !refillValid && !faultValid, "R8", "idle after stray response",
          {missReady, memReqValid, refillValid, faultValid}, 4'b1000);
    end

    rootBase = 32'h0001_0000;
    walk(32'h0040_3FFF, 0);   // back-to-back walks
    walk(32'hFFFF_FFFF, 5);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule